// File: doc/BRIEF.md
# Configuration Register Bank with Base Address Sizing

This block is the configuration register bank of a bus-attached peripheral. After reset it reads a short image from a serial EEPROM over a four-wire, SPI-style link, one 32-bit word per transfer. The image supplies the identity values and the size and kind of the single address window. While the load runs, the bank is busy. Host configuration requests made during that time are answered with a retry pulse and have no other effect. If the image is missing or malformed, the bank falls back to built-in defaults.

Once loaded, the bank serves 32-bit dword reads and writes from a simple request/acknowledge configuration port. It holds these registers:
- vendor, device, revision and class identity, all read-only;
- a small command register;
- a write-one-to-clear status register that is set by error pulses from the device core;
- one base address register (BAR).

The BAR only stores the address bits above the window size. Writing all ones and reading back therefore reveals the window size. A later write moves the window. A combinational decoder compares host addresses against the programmed window. It reports a hit, and the offset inside the window, only while the matching space enable in the command register is set.

Top module: `cfg_space_bank`

## Requirements
- R1: From reset until the EEPROM load finishes, `cfg_busy` is 1. A configuration request made while busy gives `cfg_retry`=1 and `cfg_ack`=0 on the next cycle, and it changes no register.
- R2: The load performs three SPI mode-0 transfers on word addresses 0, 1 and 2. Each transfer sends opcode 0x03 and then an 8-bit word address, MSB first, and then shifts in 32 data bits, MSB first. The image layout is:
  - word 0 = {16'hA55A, revision[7:0], io_flag[7], zero[6:5], log2_size[4:0]};
  - word 1 = {device_id, vendor_id};
  - word 2 = {class_code[23:0], 8'h00}.
  After the load, chip select stays high and the clock stays low.
- R3: The built-in defaults (vendor 0xC0DE, device 0x0100, revision 0x01, class 0xFF0000, memory window of 2^12 bytes) are used if any of these holds: the magic word differs, bits [6:5] of word 0 or bits [7:0] of word 2 are non-zero, or log2_size is below 4 for a memory window or below 2 for an I/O window.
- R4: A request made when not busy is acknowledged on the next cycle with `cfg_ack`=1. For a read, `cfg_rdata` holds the following, by dword index (other indices read 0):
  - index 0: {device, vendor};
  - index 1: {status, command};
  - index 2: {class, revision};
  - index 4: the BAR.
- R5: Writes to dword indices 0 and 2 have no effect.
- R6: Only command bits [2:0] are writable, and all other command bits read 0. Bit 0 enables the I/O window and bit 1 enables the memory window.
- R7: Status bit 11 is set by `core_err[0]` and bit 14 by `core_err[1]`. A bit is cleared by writing 1 to it (wdata bit 27 or 30). When a set and a clear happen in the same cycle, the set wins.
- R8: A BAR write keeps only bits [31:log2_size]. Lower bits read 0, except bit 0, which reads 1 for an I/O window and 0 for a memory window.
- R9: After the load, the identity and window size stay fixed until the next reset, even if the EEPROM contents change. A new reset reloads them.
- R10: `hst_hit` is 1 only when all of the following hold: `hst_io` equals the window type, the matching enable bit is set, and the host address bits at and above log2_size equal the BAR.
- R11: On a hit, `hst_loc_off` equals the host address bits below log2_size, with all upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ee_cs_n | output | 1 | EEPROM chip select, active low |
| ee_sck | output | 1 | EEPROM serial clock |
| ee_mosi | output | 1 | EEPROM serial data out |
| ee_miso | input | 1 | EEPROM serial data in |
| cfg_req | input | 1 | Configuration request strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 6 | Dword index into the configuration space |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_ack |
| cfg_ack | output | 1 | Request completed |
| cfg_retry | output | 1 | Request refused while loading |
| cfg_busy | output | 1 | EEPROM load in progress |
| core_err | input | 2 | Error event pulses from the device core |
| hst_addr | input | 32 | Host address to decode |
| hst_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| hst_hit | output | 1 | Address falls in the enabled window |
| hst_loc_off | output | 32 | Offset of the address inside the window |

## Verification
Most loader faults appear at the ports on the first read after `cfg_busy` drops. A bit misplaced in the shift register, a wrong word order or a missed validity check gives wrong identity words at once. A wrong size field gives a wrong all-ones BAR read-back. A bad address mask inside the BAR or the decoder only appears when the host address crosses the window edge, so the bench probes the first and last dword of the window and the addresses just outside it. Sticky-status faults show up on the read that follows an error pulse or a clearing write. Reload faults appear only across a second reset with a changed image.

// File: rtl/cfgs_pkg.sv
// Shared types and constants of the configuration register bank.
// Assumes a 32-bit dword configuration space indexed by dword number.
package cfgs_pkg;

    // Identity and window description produced by the EEPROM loader
    typedef struct packed {
        logic [15:0] vendor;
        logic [15:0] device;
        logic [7:0]  rev;
        logic [23:0] class_code;
        logic        bar_io;
        logic [4:0]  bar_log2;
    } ident_t;

    localparam logic [15:0] IMG_MAGIC   = 16'hA55A;
    localparam logic [7:0]  EE_OP_READ  = 8'h03;
    localparam int          IMG_WORDS   = 3;
    localparam int          EE_CMD_BITS = 16;
    localparam int          EE_DAT_BITS = 32;

    // Dword indices whose position the host software relies on
    localparam int IDX_IDENT   = 0;
    localparam int IDX_CMDSTAT = 1;
    localparam int IDX_CLASS   = 2;
    localparam int IDX_BAR     = 4;

    localparam logic [15:0] CMD_WMASK = 16'h0007;
    localparam int          N_ERR     = 2;
    localparam int          ERR_POS [N_ERR] = '{11, 14};

    // Smallest legal window exponent for each window type
    localparam logic [4:0] MIN_LOG2_IO  = 5'd2;
    localparam logic [4:0] MIN_LOG2_MEM = 5'd4;

endpackage

// File: rtl/cfgs_ee_loader.sv
// Reads the identity image from a serial EEPROM after reset.
// Three word-serial SPI mode-0 transfers (opcode, word address, 32 data bits).
// Assumes the EEPROM drives miso after the falling serial clock edge.
// Falls back to DEFAULTS when the image fails its validity checks.
module cfgs_ee_loader
    import cfgs_pkg::*;
#(
    parameter ident_t DEFAULTS = '0
) (
    input  logic   clk,
    input  logic   rst_n,
    output logic   ee_cs_n,
    output logic   ee_sck,
    output logic   ee_mosi,
    input  logic   ee_miso,
    output logic   ld_done,
    output ident_t ident
);

    localparam int XFER_BITS = EE_CMD_BITS + EE_DAT_BITS;
    localparam int CNT_W     = $clog2(XFER_BITS);
    localparam int WIDX_W    = $clog2(IMG_WORDS);

    typedef enum logic [2:0] {L_START, L_SHIFT, L_STORE, L_CHECK, L_DONE} ld_st_t;

    ld_st_t                 st;
    logic                   ph;
    logic [CNT_W-1:0]       bit_cnt;
    logic [WIDX_W-1:0]      widx;
    logic [EE_CMD_BITS-1:0] sh_out;
    logic [EE_DAT_BITS-1:0] sh_in;
    logic [31:0]            img [IMG_WORDS];
    logic                   img_ok;
    logic [4:0]             min_log2;

    // Serial data out is the MSB of the command shifter while selected
    assign ee_mosi = !ee_cs_n && sh_out[EE_CMD_BITS-1];

    // Validity rules of the loaded image
    always_comb begin
        min_log2 = img[0][7] ? MIN_LOG2_IO : MIN_LOG2_MEM;
        img_ok   = (img[0][31:16] == IMG_MAGIC) && (img[0][6:5] == 2'b00)
                 && (img[0][4:0] >= min_log2) && (img[2][7:0] == 8'h00);
    end

    // Transfer sequencer: chip select, clock phases, shifting and storing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= L_START;
            ph      <= 1'b0;
            bit_cnt <= '0;
            widx    <= '0;
            sh_out  <= '0;
            sh_in   <= '0;
            ee_cs_n <= 1'b1;
            ee_sck  <= 1'b0;
            ld_done <= 1'b0;
            ident   <= '0;
            for (int i = 0; i < IMG_WORDS; i++) img[i] <= '0;
        end else begin
            case (st)
                L_START: begin
                    ee_cs_n <= 1'b0;
                    ph      <= 1'b0;
                    bit_cnt <= '0;
                    sh_out  <= {EE_OP_READ, 8'(widx)};
                    st      <= L_SHIFT;
                end
                L_SHIFT: begin
                    if (!ph) begin
                        ee_sck <= 1'b1;
                        ph     <= 1'b1;
                    end else begin
                        ee_sck <= 1'b0;
                        ph     <= 1'b0;
                        sh_out <= {sh_out[EE_CMD_BITS-2:0], 1'b0};
                        if (bit_cnt >= CNT_W'(EE_CMD_BITS))
                            sh_in <= {sh_in[EE_DAT_BITS-2:0], ee_miso};
                        if (bit_cnt == CNT_W'(XFER_BITS - 1))
                            st <= L_STORE;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                L_STORE: begin
                    ee_cs_n   <= 1'b1;
                    img[widx] <= sh_in;
                    if (widx == WIDX_W'(IMG_WORDS - 1)) begin
                        st <= L_CHECK;
                    end else begin
                        widx <= widx + 1'b1;
                        st   <= L_START;
                    end
                end
                L_CHECK: begin
                    if (img_ok) begin
                        ident.vendor     <= img[1][15:0];
                        ident.device     <= img[1][31:16];
                        ident.rev        <= img[0][15:8];
                        ident.class_code <= img[2][31:8];
                        ident.bar_io     <= img[0][7];
                        ident.bar_log2   <= img[0][4:0];
                    end else begin
                        ident <= DEFAULTS;
                    end
                    ld_done <= 1'b1;
                    st      <= L_DONE;
                end
                default: st <= L_DONE;
            endcase
        end
    end

endmodule

// File: rtl/cfgs_regfile.sv
// Host-visible configuration registers: identity, command, status and BAR.
// Assumes one request per cycle at most; replies one cycle later.
// Refuses every request with a retry pulse until ld_done is set.
module cfgs_regfile
    import cfgs_pkg::*;
#(
    parameter int CFG_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ident_t            ident,
    input  logic              ld_done,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [N_ERR-1:0]  core_err,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_ack,
    output logic              cfg_retry,
    output logic [15:0]       cmd_q,
    output logic [15:0]       status_q,
    output logic [31:0]       bar_q,
    output logic [31:0]       bar_mask
);

    logic        wr_ok;
    logic [15:0] stat_set;
    logic [15:0] stat_clr;
    logic [15:0] stat_w1c;
    logic [31:0] rd_mux;

    assign wr_ok    = cfg_req && cfg_we && ld_done;
    assign bar_mask = ~((32'h1 << ident.bar_log2) - 32'h1);

    // Map core error pulses onto their sticky status bits
    always_comb begin
        stat_set = '0;
        stat_w1c = '0;
        for (int i = 0; i < N_ERR; i++) begin
            stat_set[ERR_POS[i]] = core_err[i];
            stat_w1c[ERR_POS[i]] = 1'b1;
        end
        stat_clr = (wr_ok && cfg_addr == CFG_AW'(IDX_CMDSTAT))
                 ? (cfg_wdata[31:16] & stat_w1c) : 16'h0;
    end

    // Read data selection by dword index
    always_comb begin
        case (cfg_addr)
            CFG_AW'(IDX_IDENT):   rd_mux = {ident.device, ident.vendor};
            CFG_AW'(IDX_CMDSTAT): rd_mux = {status_q, cmd_q};
            CFG_AW'(IDX_CLASS):   rd_mux = {ident.class_code, ident.rev};
            CFG_AW'(IDX_BAR):     rd_mux = bar_q | {31'h0, ident.bar_io};
            default:              rd_mux = 32'h0;
        endcase
    end

    // Register updates and the one-cycle request reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            status_q  <= '0;
            bar_q     <= '0;
            cfg_ack   <= 1'b0;
            cfg_retry <= 1'b0;
            cfg_rdata <= '0;
        end else begin
            status_q  <= (status_q & ~stat_clr) | stat_set;
            cfg_ack   <= cfg_req && ld_done;
            cfg_retry <= cfg_req && !ld_done;
            cfg_rdata <= (cfg_req && ld_done && !cfg_we) ? rd_mux : 32'h0;
            if (wr_ok && cfg_addr == CFG_AW'(IDX_CMDSTAT))
                cmd_q <= cfg_wdata[15:0] & CMD_WMASK;
            if (wr_ok && cfg_addr == CFG_AW'(IDX_BAR))
                bar_q <= cfg_wdata & bar_mask;
        end
    end

endmodule

// File: rtl/cfgs_bar_decode.sv
// Window match and translation for the single BAR.
// Purely combinational; assumes bar_q holds no bits outside bar_mask.
module cfgs_bar_decode #(
    parameter int HA_W = 32
) (
    input  logic [HA_W-1:0] hst_addr,
    input  logic            hst_io,
    input  logic [HA_W-1:0] bar_q,
    input  logic [HA_W-1:0] bar_mask,
    input  logic            bar_io,
    input  logic            io_en,
    input  logic            mem_en,
    output logic            hit,
    output logic [HA_W-1:0] loc_off
);

    logic space_en;

    // Enable, type match and base compare, then offset extraction
    always_comb begin
        space_en = bar_io ? io_en : mem_en;
        hit      = space_en && (hst_io == bar_io)
                 && ((hst_addr & bar_mask) == bar_q);
        loc_off  = hst_addr & ~bar_mask;
    end

endmodule

// File: rtl/cfg_space_bank.sv
// Configuration register bank: EEPROM preload, host register access and
// BAR window decode. Assumes a synchronous active-low reset that is held
// for at least one clock; the EEPROM is read once per reset.
module cfg_space_bank
    import cfgs_pkg::*;
#(
    parameter int          CFG_AW       = 6,
    parameter logic [15:0] DEF_VENDOR   = 16'hC0DE,
    parameter logic [15:0] DEF_DEVICE   = 16'h0100,
    parameter logic [7:0]  DEF_REV      = 8'h01,
    parameter logic [23:0] DEF_CLASS    = 24'hFF0000,
    parameter logic        DEF_BAR_IO   = 1'b0,
    parameter logic [4:0]  DEF_BAR_LOG2 = 5'd12
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ee_cs_n,
    output logic              ee_sck,
    output logic              ee_mosi,
    input  logic              ee_miso,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_ack,
    output logic              cfg_retry,
    output logic              cfg_busy,
    input  logic [N_ERR-1:0]  core_err,
    input  logic [31:0]       hst_addr,
    input  logic              hst_io,
    output logic              hst_hit,
    output logic [31:0]       hst_loc_off
);

    localparam ident_t DEFAULTS = '{
        vendor: DEF_VENDOR, device: DEF_DEVICE, rev: DEF_REV,
        class_code: DEF_CLASS, bar_io: DEF_BAR_IO, bar_log2: DEF_BAR_LOG2
    };

    ident_t      ident;
    logic        ld_done;
    logic [15:0] cmd_q;
    logic [15:0] status_q;
    logic [31:0] bar_q;
    logic [31:0] bar_mask;

    assign cfg_busy = !ld_done;

    cfgs_ee_loader #(.DEFAULTS(DEFAULTS)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .ee_cs_n (ee_cs_n),
        .ee_sck  (ee_sck),
        .ee_mosi (ee_mosi),
        .ee_miso (ee_miso),
        .ld_done (ld_done),
        .ident   (ident)
    );

    cfgs_regfile #(.CFG_AW(CFG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ident     (ident),
        .ld_done   (ld_done),
        .cfg_req   (cfg_req),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .core_err  (core_err),
        .cfg_rdata (cfg_rdata),
        .cfg_ack   (cfg_ack),
        .cfg_retry (cfg_retry),
        .cmd_q     (cmd_q),
        .status_q  (status_q),
        .bar_q     (bar_q),
        .bar_mask  (bar_mask)
    );

    cfgs_bar_decode #(.HA_W(32)) u_dec (
        .hst_addr (hst_addr),
        .hst_io   (hst_io),
        .bar_q    (bar_q),
        .bar_mask (bar_mask),
        .bar_io   (ident.bar_io),
        .io_en    (cmd_q[0]),
        .mem_en   (cmd_q[1]),
        .hit      (hst_hit),
        .loc_off  (hst_loc_off)
    );

endmodule

// File: rtl/cfgs_checker.sv
// Temporal checks on the configuration register bank, bound to its top.
module cfgs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_req,
    input logic        cfg_busy,
    input logic        cfg_ack,
    input logic        cfg_retry,
    input logic        ee_cs_n,
    input logic        ee_sck,
    input logic [1:0]  core_err,
    input logic        stat_ta,
    input logic        stat_se,
    input logic        io_en,
    input logic        mem_en,
    input logic        bar_io,
    input logic [31:0] bar_q,
    input logic [31:0] bar_mask,
    input logic [31:0] hst_addr,
    input logic        hst_io,
    input logic        hst_hit,
    input logic [31:0] hst_loc_off
);

    AST_RETRY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && cfg_busy |=> cfg_retry && !cfg_ack); // R1
    AST_ACK_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_busy |=> cfg_ack && !cfg_retry); // R4
    AST_EE_QUIET_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_busy |-> ee_cs_n && !ee_sck); // R2
    AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_busy |=> !cfg_busy); // R9
    AST_MASK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_busy && $past(!cfg_busy) |-> $stable(bar_mask)); // R9
    AST_BAR_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_q & ~bar_mask) == 32'h0); // R8
    AST_STAT_TA_SET: assert property (@(posedge clk) disable iff (!rst_n)
        core_err[0] |=> stat_ta); // R7
    AST_STAT_SE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        core_err[1] |=> stat_se); // R7
    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hst_hit |-> (bar_io ? io_en : mem_en)); // R10
    AST_HIT_TYPE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hst_hit |-> hst_io == bar_io); // R10
    AST_OFFSET_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        hst_hit |-> ((hst_loc_off & bar_mask) == 32'h0)
                    && ((hst_loc_off | bar_q) == hst_addr)); // R11

endmodule

bind cfg_space_bank cfgs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_req     (cfg_req),
    .cfg_busy    (cfg_busy),
    .cfg_ack     (cfg_ack),
    .cfg_retry   (cfg_retry),
    .ee_cs_n     (ee_cs_n),
    .ee_sck      (ee_sck),
    .core_err    (core_err),
    .stat_ta     (status_q[11]),
    .stat_se     (status_q[14]),
    .io_en       (cmd_q[0]),
    .mem_en      (cmd_q[1]),
    .bar_io      (ident.bar_io),
    .bar_q       (bar_q),
    .bar_mask    (bar_mask),
    .hst_addr    (hst_addr),
    .hst_io      (hst_io),
    .hst_hit     (hst_hit),
    .hst_loc_off (hst_loc_off)
);

// File: tb/cfg_space_bank_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, with an EEPROM model.
module cfg_space_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ee_cs_n, ee_sck, ee_mosi, ee_miso;
    logic        cfg_req = 1'b0, cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_ack, cfg_retry, cfg_busy;
    logic [1:0]  core_err = '0;
    logic [31:0] hst_addr = '0;
    logic        hst_io = 1'b0;
    logic        hst_hit;
    logic [31:0] hst_loc_off;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cfg_space_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .ee_cs_n(ee_cs_n), .ee_sck(ee_sck), .ee_mosi(ee_mosi), .ee_miso(ee_miso),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_ack(cfg_ack),
        .cfg_retry(cfg_retry), .cfg_busy(cfg_busy), .core_err(core_err),
        .hst_addr(hst_addr), .hst_io(hst_io), .hst_hit(hst_hit),
        .hst_loc_off(hst_loc_off)
    );

    // ---------------- EEPROM model ----------------
    logic [31:0] ee_img [3];
    logic        ee_dead = 1'b0;
    int          ee_cnt = 0;
    logic [15:0] ee_cmd = '0;
    logic        ee_bit = 1'b0;

    assign ee_miso = ee_dead ? 1'b1 : ee_bit;

    always @(posedge ee_sck or posedge ee_cs_n) begin
        if (ee_cs_n) begin
            ee_cnt <= 0;
        end else begin
            if (ee_cnt < 16) ee_cmd <= {ee_cmd[14:0], ee_mosi};
            ee_cnt <= ee_cnt + 1;
        end
    end

    always @(negedge ee_sck) begin
        if (ee_cnt >= 16 && ee_cnt < 48 && ee_cmd[15:8] == 8'h03 && ee_cmd[7:0] < 3)
            ee_bit <= ee_img[ee_cmd[1:0]][31 - (ee_cnt - 16)];
        else
            ee_bit <= 1'b0;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic cfg_rd(input logic [5:0] idx, output logic [31:0] data,
                          output logic ack, output logic rty);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b0; cfg_addr = idx;
        @(negedge clk);
        cfg_req = 1'b0;
        data = cfg_rdata; ack = cfg_ack; rty = cfg_retry;
    endtask

    task automatic cfg_wr(input logic [5:0] idx, input logic [31:0] data, output logic ack);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_req = 1'b0; cfg_we = 1'b0;
        ack = cfg_ack;
    endtask

    task automatic rd_expect(input string tag, input logic [5:0] idx, input logic [31:0] exp);
        logic [31:0] d; logic a, r;
        cfg_rd(idx, d, a, r);
        chk({tag, " ack"}, {31'h0, a}, 32'h1);
        chk(tag, d, exp);
    endtask

    task automatic wr_do(input string tag, input logic [5:0] idx, input logic [31:0] data);
        logic a;
        cfg_wr(idx, data, a);
        chk({tag, " write ack"}, {31'h0, a}, 32'h1);
    endtask

    task automatic decode_expect(input string tag, input logic [31:0] addr, input logic io,
                                 input logic exp_hit, input logic [31:0] exp_off);
        @(negedge clk);
        hst_addr = addr; hst_io = io;
        #5;
        chk({tag, " hit"}, {31'h0, hst_hit}, {31'h0, exp_hit});
        if (exp_hit) chk({tag, " offset"}, hst_loc_off, exp_off);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_load();
        for (int i = 0; i < 3000 && cfg_busy; i++) @(negedge clk);
        chk("R1 busy drops after load", {31'h0, cfg_busy}, 32'h0);
    endtask

    task automatic load_image(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
        ee_img[0] = w0; ee_img[1] = w1; ee_img[2] = w2;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_busy();
        logic [31:0] d; logic a, r;
        logic a_w;
        do_reset();
        @(negedge clk);
        chk("R1 busy after reset", {31'h0, cfg_busy}, 32'h1);
        chk("R1 no hit after reset", {31'h0, hst_hit}, 32'h0);
        cfg_rd(6'd0, d, a, r);
        chk("R1 retry while busy", {31'h0, r}, 32'h1);
        chk("R1 no ack while busy", {31'h0, a}, 32'h0);
        cfg_wr(6'd1, 32'h0000_0007, a_w);
        chk("R1 write refused while busy", {31'h0, a_w}, 32'h0);
        wait_load();
        chk("R2 chip select idle", {31'h0, ee_cs_n}, 32'h1);
        rd_expect("R1 busy write had no effect on command", 6'd1, 32'h0);
    endtask

    task automatic t_identity();
        rd_expect("R2 R4 ident word", 6'd0, 32'h7A31_19E5);
        rd_expect("R2 R4 class word", 6'd2, 32'h0B40_013C);
        rd_expect("R4 unused index reads zero", 6'd3, 32'h0);
    endtask

    task automatic t_id_writes();
        wr_do("R5", 6'd0, 32'h0000_0000);
        wr_do("R5", 6'd2, 32'hFFFF_FFFF);
        rd_expect("R5 ident unchanged", 6'd0, 32'h7A31_19E5);
        rd_expect("R5 class unchanged", 6'd2, 32'h0B40_013C);
    endtask

    task automatic t_command();
        wr_do("R6", 6'd1, 32'h0000_FFFF);
        rd_expect("R6 command mask", 6'd1, 32'h0000_0007);
        wr_do("R6", 6'd1, 32'h0000_0000);
        rd_expect("R6 command cleared", 6'd1, 32'h0);
    endtask

    task automatic t_status();
        @(negedge clk); core_err = 2'b11;
        @(negedge clk); core_err = 2'b00;
        rd_expect("R7 both status bits set", 6'd1, 32'h4800_0000);
        wr_do("R7", 6'd1, 32'h0800_0000);
        rd_expect("R7 bit 11 cleared alone", 6'd1, 32'h4000_0000);
        // Set and clear of bit 14 in the same cycle: set wins
        @(negedge clk);
        core_err = 2'b10; cfg_req = 1'b1; cfg_we = 1'b1; cfg_addr = 6'd1; cfg_wdata = 32'h4000_0000;
        @(negedge clk);
        core_err = 2'b00; cfg_req = 1'b0; cfg_we = 1'b0;
        rd_expect("R7 set wins over clear", 6'd1, 32'h4000_0000);
        wr_do("R7", 6'd1, 32'h4000_0000);
        rd_expect("R7 bit 14 cleared", 6'd1, 32'h0);
    endtask

    task automatic t_bar_probe_mem();
        wr_do("R8", 6'd4, 32'hFFFF_FFFF);
        rd_expect("R8 1MB memory size probe", 6'd4, 32'hFFF0_0000);
        wr_do("R8", 6'd4, 32'h1234_5678);
        rd_expect("R8 low bits dropped", 6'd4, 32'h1230_0000);
    endtask

    task automatic t_decode_mem();
        wr_do("R10", 6'd4, 32'h4AB0_0000);
        decode_expect("R10 disabled window", 32'h4AB0_0000, 1'b0, 1'b0, 32'h0);
        wr_do("R10", 6'd1, 32'h0000_0002);
        decode_expect("R10 R11 window base", 32'h4AB0_0000, 1'b0, 1'b1, 32'h0);
        decode_expect("R10 R11 window top", 32'h4ABF_FFFC, 1'b0, 1'b1, 32'h000F_FFFC);
        decode_expect("R10 above window", 32'h4AC0_0000, 1'b0, 1'b0, 32'h0);
        decode_expect("R10 below window", 32'h4AAF_FFFF, 1'b0, 1'b0, 32'h0);
        decode_expect("R10 wrong space type", 32'h4AB0_0010, 1'b1, 1'b0, 32'h0);
        wr_do("R10", 6'd1, 32'h0000_0001);
        decode_expect("R10 only io enabled", 32'h4AB0_0010, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_reload_io();
        load_image(32'hA55A_0788, 32'h5C02_19E5, 32'h0C03_3000);
        rd_expect("R9 ident kept until reset", 6'd0, 32'h7A31_19E5);
        do_reset();
        wait_load();
        rd_expect("R9 ident reloaded", 6'd0, 32'h5C02_19E5);
        rd_expect("R9 class reloaded", 6'd2, 32'h0C03_3007);
        wr_do("R8", 6'd4, 32'hFFFF_FFFF);
        rd_expect("R8 io size probe", 6'd4, 32'hFFFF_FF01);
        wr_do("R8", 6'd4, 32'h0000_C0AB);
        rd_expect("R8 io relocation", 6'd4, 32'h0000_C001);
        wr_do("R10", 6'd1, 32'h0000_0001);
        decode_expect("R10 R11 io window top", 32'h0000_C0FF, 1'b1, 1'b1, 32'h0000_00FF);
        decode_expect("R10 io above window", 32'h0000_C100, 1'b1, 1'b0, 32'h0);
        decode_expect("R10 io memory cycle", 32'h0000_C004, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_fallback();
        load_image(32'hA55A_0003, 32'h5C02_19E5, 32'h0C03_3000);
        do_reset();
        wait_load();
        rd_expect("R3 small window uses defaults", 6'd0, 32'h0100_C0DE);
        rd_expect("R3 default class", 6'd2, 32'hFF00_0001);
        wr_do("R3", 6'd4, 32'hFFFF_FFFF);
        rd_expect("R3 default window size", 6'd4, 32'hFFFF_F000);
        ee_dead = 1'b1;
        do_reset();
        wait_load();
        rd_expect("R3 absent EEPROM uses defaults", 6'd0, 32'h0100_C0DE);
        ee_dead = 1'b0;
        load_image(32'hA55A_3C14, 32'h7A31_19E5, 32'h0B40_0101);
        do_reset();
        wait_load();
        rd_expect("R3 reserved byte set uses defaults", 6'd0, 32'h0100_C0DE);
    endtask

    // ---------------- main ----------------
    initial begin
        load_image(32'hA55A_3C14, 32'h7A31_19E5, 32'h0B40_0100);
        t_reset_busy();
        t_identity();
        t_id_writes();
        t_command();
        t_status();
        t_bar_probe_mem();
        t_decode_mem();
        t_reload_io();
        t_fallback();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule